// File: doc/BRIEF.md
# Fast Back-to-Back Window Qualifier

This block sits beside a PCI host bridge. For every access the bridge is about to issue as bus master, it decides whether the access may be chained as a fast back-to-back transfer. The decision uses two programmable address windows that share one mask. The upper 16 bits of the physical address are masked and compared against each window base. A match in either window qualifies the access, but only while the fast back-to-back enable bit from the bridge command register is set.

The mask and the two bases share three 32-bit processor registers with identification fields. These are the upper 16 bits of the class code, the subsystem vendor ID and the subsystem ID. When the bridge acts as a satellite device, PCI configuration reads of the class-code dword and the subsystem dword are answered from these fields. The configuration side can read these registers but has no way to write them.

Processor register map, by byte offset. Bits 31:16 hold the window field and bits 15:0 hold the identification field:
- 0x08: shared mask, and the class code upper 16 bits.
- 0x0C: base of window 0, and the subsystem vendor ID.
- 0x10: base of window 1, and the subsystem ID.

Top module: `fbb_qualifier`

## Requirements
- R1: After reset all three registers read as zero, cpu_rdata is zero, cfg_rdata is zero and cfg_claim is low.
- R2: A processor write with cpu_addr equal to 0x08, 0x0C or 0x10 stores all 32 bits of cpu_wdata in that register. A write to any other byte address, including unaligned ones, changes no register.
- R3: A processor read presents the addressed register on cpu_rdata after the next rising edge. An unmapped address reads as zero. cpu_rdata keeps its value while cpu_rd_en is low.
- R4: win_hit[i] is high when (acc_addr[31:16] & mask) equals base i, where mask is bits 31:16 at 0x08 and the base is bits 31:16 at 0x0C (i=0) or 0x10 (i=1). The base itself is not masked. acc_addr[15:0] has no effect.
- R5: fbb_ok is high exactly when acc_valid, fbb_enable and at least one win_hit bit are all high. While fbb_enable is low, fbb_ok stays low, even with the all-zero reset values that match every address.
- R6: In satellite mode, a configuration read of byte address 0x08 returns {class code upper 16 bits, class_sub[7:0], rev_id[7:0]} on cfg_rdata one cycle later, with cfg_claim high for that cycle.
- R7: In satellite mode, a configuration read of byte address 0x2C returns {subsystem ID, subsystem vendor ID} one cycle later, with cfg_claim high.
- R8: A configuration read of any other address, or any read while satellite_mode is low, returns cfg_claim low and cfg_rdata zero. Configuration reads never modify any register.
- R9: When a processor read and a processor write address the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_rd_en | input | 1 | Processor read strobe |
| cpu_addr | input | 8 | Processor register byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Registered processor read data |
| fbb_enable | input | 1 | Fast back-to-back enable bit from the command register |
| acc_valid | input | 1 | A master access is being qualified |
| acc_addr | input | 32 | Physical address of the master access |
| win_hit | output | 2 | Per-window match |
| fbb_ok | output | 1 | Fast back-to-back may be attempted |
| satellite_mode | input | 1 | Bridge answers configuration cycles |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte address |
| class_sub | input | 8 | Lower class-code byte |
| rev_id | input | 8 | Revision ID |
| cfg_rdata | output | 32 | Registered configuration read data |
| cfg_claim | output | 1 | The configuration read hit an owned dword |

## Verification
The bench builds the block with its default values: a 32-bit address and two windows. This is the full register layout, so every mask/base combination can be reached through the processor port. Random masks and bases are paired with addresses built to fall inside a window or outside it, and the low 16 address bits are randomized. This covers single hits, double hits and misses. Directed cases cover the all-zero reset match under a cleared enable, unaligned and unmapped offsets, and a read and write colliding on the same register.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  localparam int FIELD_W = 16;
  localparam int REG_W   = 2 * FIELD_W;

  // processor byte offsets
  localparam logic [7:0] CPU_OFF_MASK  = 8'h08;
  localparam logic [7:0] CPU_OFF_BASE0 = 8'h0C;
  localparam logic [7:0] CPU_OFF_BASE1 = 8'h10;

  // configuration byte addresses answered in satellite mode
  localparam logic [7:0] CFG_OFF_CLASS  = 8'h08;
  localparam logic [7:0] CFG_OFF_SUBSYS = 8'h2C;

  typedef struct packed {
    logic [FIELD_W-1:0] win;  // mask or base
    logic [FIELD_W-1:0] id;   // identification field
  } fbb_reg_t;

  function automatic logic window_match(input logic [FIELD_W-1:0] a_hi,
                                        input logic [FIELD_W-1:0] mask,
                                        input logic [FIELD_W-1:0] base);
    return ((a_hi & mask) == base);
  endfunction
endpackage

// File: rtl/fbb_regs.sv
module fbb_regs
  import fbb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output fbb_reg_t         r_mask,
  output fbb_reg_t         r_base0,
  output fbb_reg_t         r_base1
);
  logic wr_mask, wr_base0, wr_base1, wr_any;
  logic [REG_W-1:0] rd_mux;

  assign wr_mask  = wr_en && (addr == CPU_OFF_MASK);
  assign wr_base0 = wr_en && (addr == CPU_OFF_BASE0);
  assign wr_base1 = wr_en && (addr == CPU_OFF_BASE1);
  assign wr_any   = wr_mask || wr_base0 || wr_base1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_mask  <= '0;
      r_base0 <= '0;
      r_base1 <= '0;
    end else begin
      if (wr_mask)  r_mask  <= fbb_reg_t'(wdata);
      if (wr_base0) r_base0 <= fbb_reg_t'(wdata);
      if (wr_base1) r_base1 <= fbb_reg_t'(wdata);
    end
  end

  always_comb begin
    unique case (addr)
      CPU_OFF_MASK:  rd_mux = r_mask;
      CPU_OFF_BASE0: rd_mux = r_base0;
      CPU_OFF_BASE1: rd_mux = r_base1;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2: a decoded write lands the full word
  p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (r_mask == $past(wdata)));
  // R2/R8: without a decoded write no register moves
  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> ($stable(r_mask) && $stable(r_base0) && $stable(r_base1)));
  // R3: read data holds between reads
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/fbb_window_match.sv
module fbb_window_match
  import fbb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2
) (
  input  logic [ADDR_W-1:0]               acc_addr,
  input  logic [FIELD_W-1:0]              mask,
  input  logic [NUM_WIN-1:0][FIELD_W-1:0] bases,
  output logic [NUM_WIN-1:0]              hit
);
  localparam int HI_LSB = ADDR_W - FIELD_W;

  logic [FIELD_W-1:0] addr_hi;
  logic               unused_addr_lo;

  assign addr_hi        = acc_addr[ADDR_W-1:HI_LSB];
  assign unused_addr_lo = ^acc_addr[HI_LSB-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit[w] = window_match(addr_hi, mask, bases[w]);
  end

  // R4: a window whose base has bits outside the mask can never match
  always_comb begin
    for (int w = 0; w < NUM_WIN; w++)
      if ((bases[w] & ~mask) != '0)
        p_unreachable_base_r4: assert (!hit[w]);
  end
endmodule

// File: rtl/fbb_cfg_view.sv
module fbb_cfg_view
  import fbb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [7:0]         addr,
  input  logic               satellite,
  input  logic [FIELD_W-1:0] class_hi,
  input  logic [7:0]         class_sub,
  input  logic [7:0]         rev_id,
  input  logic [FIELD_W-1:0] svid,
  input  logic [FIELD_W-1:0] subid,
  output logic [REG_W-1:0]   rdata,
  output logic               claim
);
  logic             sel_class, sel_subsys, owned;
  logic [REG_W-1:0] view;

  assign sel_class  = (addr == CFG_OFF_CLASS);
  assign sel_subsys = (addr == CFG_OFF_SUBSYS);
  assign owned      = satellite && (sel_class || sel_subsys);

  always_comb begin
    view = '0;
    if (satellite) begin
      if (sel_class)  view = {class_hi, class_sub, rev_id};
      if (sel_subsys) view = {subid, svid};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      claim <= 1'b0;
    end else begin
      claim <= rd_en && owned;
      if (rd_en) rdata <= view;
    end
  end

  // R8: a claim only follows a read made in satellite mode
  p_claim_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> ($past(rd_en) && $past(satellite)));
  // R8: an unowned read returns zero data
  p_unowned_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !owned) |=> (rdata == '0 && !claim));
endmodule

// File: rtl/fbb_qualifier.sv
module fbb_qualifier
  import fbb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic              cpu_rd_en,
  input  logic [7:0]        cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              fbb_enable,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NUM_WIN-1:0] win_hit,
  output logic              fbb_ok,
  input  logic              satellite_mode,
  input  logic              cfg_rd_en,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        class_sub,
  input  logic [7:0]        rev_id,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_claim
);
  fbb_reg_t r_mask, r_base0, r_base1;
  logic [NUM_WIN-1:0][FIELD_W-1:0] bases;
  logic any_hit;

  fbb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en), .rd_en(cpu_rd_en),
    .addr(cpu_addr), .wdata(cpu_wdata), .rdata(cpu_rdata),
    .r_mask(r_mask), .r_base0(r_base0), .r_base1(r_base1)
  );

  // window i takes its base from the i-th register after the mask
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_base
    if (w == 0) begin : g_b0
      assign bases[w] = r_base0.win;
    end else begin : g_b1
      assign bases[w] = r_base1.win;
    end
  end

  fbb_window_match #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_match (
    .acc_addr(acc_addr), .mask(r_mask.win), .bases(bases), .hit(win_hit)
  );

  assign any_hit = |win_hit;
  assign fbb_ok  = acc_valid && fbb_enable && any_hit;

  fbb_cfg_view u_cfg (
    .clk(clk), .rst_n(rst_n), .rd_en(cfg_rd_en), .addr(cfg_addr),
    .satellite(satellite_mode), .class_hi(r_mask.id), .class_sub(class_sub),
    .rev_id(rev_id), .svid(r_base0.id), .subid(r_base1.id),
    .rdata(cfg_rdata), .claim(cfg_claim)
  );

  // R5: the enable bit gates every qualification
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fbb_enable |-> !fbb_ok);
  // R5: qualification needs a live access
  p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fbb_ok |-> (acc_valid && $countones(win_hit) > 0));
endmodule

// File: tb/fbb_qualifier_tb.sv
module fbb_qualifier_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 0, cpu_rd_en = 0;
  logic [7:0]  cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic [31:0] cpu_rdata;
  logic        fbb_enable = 0, acc_valid = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0]  win_hit;
  logic        fbb_ok;
  logic        satellite_mode = 0, cfg_rd_en = 0;
  logic [7:0]  cfg_addr = 0, class_sub = 8'h00, rev_id = 8'h00;
  logic [31:0] cfg_rdata;
  logic        cfg_claim;

  int n_chk = 0, n_bad = 0;
  logic [31:0] sh_mask = 0, sh_b0 = 0, sh_b1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbb_qualifier dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hits(input logic [31:0] a);
    logic [15:0] m = a[31:16] & sh_mask[31:16];
    return {m == sh_b1[31:16], m == sh_b0[31:16]};
  endfunction

  task automatic cpu_wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk); cpu_wr_en = 1; cpu_addr = off; cpu_wdata = d;
    @(negedge clk); cpu_wr_en = 0;
    if (off == 8'h08) sh_mask = d;
    if (off == 8'h0C) sh_b0 = d;
    if (off == 8'h10) sh_b1 = d;
  endtask

  task automatic cpu_rd(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk); cpu_rd_en = 1; cpu_addr = off;
    @(negedge clk); cpu_rd_en = 0; d = cpu_rdata;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d, output logic c);
    @(negedge clk); cfg_rd_en = 1; cfg_addr = a;
    @(negedge clk); cfg_rd_en = 0; d = cfg_rdata; c = cfg_claim;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] d;
    cpu_rd(8'h08, d); check(req, d, sh_mask);
    cpu_rd(8'h0C, d); check(req, d, sh_b0);
    cpu_rd(8'h10, d); check(req, d, sh_b1);
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic v, input logic en);
    logic [1:0] h;
    @(negedge clk); acc_addr = a; acc_valid = v; fbb_enable = en;
    #1;
    h = exp_hits(a);
    check({req, " win_hit"}, {30'b0, win_hit}, {30'b0, h});
    check("R5 fbb_ok", {31'b0, fbb_ok}, {31'b0, v & en & (|h)});
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, hold;
    logic c;
    void'($urandom(32'h5EED_0123));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 cpu_rdata", cpu_rdata, 32'h0);
    check("R1 cfg_rdata", cfg_rdata, 32'h0);
    check("R1 cfg_claim", {31'b0, cfg_claim}, 32'h0);
    check_regs("R1 reset regs");
    // R5: zero regs match everything, but enable low keeps fbb_ok low
    probe("R4 reset", 32'hDEAD_BEEF, 1'b1, 1'b0);
    check("R5 disabled at reset", {31'b0, fbb_ok}, 32'h0);
    probe("R4 reset", 32'hDEAD_BEEF, 1'b1, 1'b1);
    check("R5 enabled at reset", {31'b0, fbb_ok}, 32'h1);

    // R2 writes, unaligned and unmapped writes ignored
    cpu_wr(8'h08, 32'hFF00_1234);
    cpu_wr(8'h0C, 32'hAB00_5678);
    cpu_wr(8'h10, 32'hCD00_9ABC);
    check_regs("R2 mapped writes");
    cpu_wr(8'h09, 32'h1111_1111);
    cpu_wr(8'h14, 32'h2222_2222);
    cpu_wr(8'h00, 32'h3333_3333);
    check_regs("R2 ignored writes");
    // R3 unmapped read and hold
    cpu_rd(8'h04, d); check("R3 unmapped read", d, 32'h0);
    cpu_rd(8'h10, d); hold = d;
    repeat (3) @(negedge clk);
    check("R3 rdata holds", cpu_rdata, hold);

    // R4 directed: low address bits ignored, base not masked
    probe("R4 hit w0", 32'hAB12_0000, 1'b1, 1'b1);
    probe("R4 low bits", 32'hAB77_FFFF, 1'b1, 1'b1);
    probe("R4 hit w1", 32'hCD00_1234, 1'b1, 1'b1);
    probe("R4 miss", 32'h0100_0000, 1'b1, 1'b1);
    probe("R5 no valid", 32'hCD00_0000, 1'b0, 1'b1);
    cpu_wr(8'h0C, 32'h00FF_5678); // base bits outside the mask: never matches
    probe("R4 unreachable", 32'h00FF_0000, 1'b1, 1'b1);
    check("R4 unreachable base", {30'b0, win_hit}, 32'h0);

    // R9 read/write collision
    @(negedge clk);
    cpu_wr_en = 1; cpu_rd_en = 1; cpu_addr = 8'h08; cpu_wdata = 32'h0F0F_AAAA;
    @(negedge clk);
    cpu_wr_en = 0; cpu_rd_en = 0;
    check("R9 old value", cpu_rdata, sh_mask);
    sh_mask = 32'h0F0F_AAAA;
    check_regs("R9 write landed");

    // R6/R7/R8 configuration view
    cpu_wr(8'h0C, 32'h0000_1022);
    cpu_wr(8'h10, 32'h0000_C0DE);
    class_sub = 8'h80; rev_id = 8'h3A;
    satellite_mode = 1;
    cfg_rd(8'h08, d, c);
    check("R6 class data", d, {sh_mask[15:0], 8'h80, 8'h3A});
    check("R6 claim", {31'b0, c}, 32'h1);
    @(negedge clk);
    check("R6 claim one cycle", {31'b0, cfg_claim}, 32'h0);
    cfg_rd(8'h2C, d, c);
    check("R7 subsys data", d, {sh_b1[15:0], sh_b0[15:0]});
    check("R7 claim", {31'b0, c}, 32'h1);
    cfg_rd(8'h10, d, c);
    check("R8 other addr data", d, 32'h0);
    check("R8 other addr claim", {31'b0, c}, 32'h0);
    satellite_mode = 0;
    cfg_rd(8'h2C, d, c);
    check("R8 not satellite data", d, 32'h0);
    check("R8 not satellite claim", {31'b0, c}, 32'h0);
    check_regs("R8 cfg reads leave regs");

    // constrained random windows and addresses
    for (int it = 0; it < 40; it++) begin
      logic [31:0] m, b0, b1, a;
      m  = {$urandom() & ~(32'h1 << ($urandom() % 16)), 16'h0};
      m[15:0] = $urandom();
      b0 = $urandom(); b1 = $urandom();
      if ($urandom() % 4 != 0) b0[31:16] = b0[31:16] & m[31:16];
      if ($urandom() % 4 != 0) b1[31:16] = b1[31:16] & m[31:16];
      if (it % 10 == 0) b1[31:16] = b0[31:16];
      cpu_wr(8'h08, m); cpu_wr(8'h0C, b0); cpu_wr(8'h10, b1);
      for (int k = 0; k < 12; k++) begin
        a = $urandom();
        case (k % 3)
          0: a[31:16] = (sh_b0[31:16] & sh_mask[31:16]) | (a[31:16] & ~sh_mask[31:16]);
          1: a[31:16] = (sh_b1[31:16] & sh_mask[31:16]) | (a[31:16] & ~sh_mask[31:16]);
          default: ;
        endcase
        probe("R4 random", a, ($urandom() % 8) != 0, ($urandom() % 6) != 0);
      end
      if (it % 8 == 0) check_regs("R2 random readback");
    end
    finish_run();
  end
endmodule